// File: doc/BRIEF.md
# Bit-banged serial EEPROM engine

This block models a small three-wire serial EEPROM of 128 words of 16 bits. Software drives it through a single byte register in a memory-mapped window. It toggles chip-select, clock and data-in bits by writing that register and reads the data-out bit back from it. The engine watches the written values for edges. A rising clock while idle with data-in high is a start bit. Ten command bits follow, most significant first. The command is then decoded, and the engine performs a read, a write, an erase, a write-all, an erase-all, or a change of the write-enable latch against its internal word array.

The window is closed until two enable writes have been made. One value goes to control region 0 and another to control region 2. The same window also holds a two-step trigger: two writes to two offsets produce a one-cycle sample strobe for an external sensor. The sensor values themselves and any persistence of the array are outside this block.

Top module: `ser_eeprom_top`

## Requirements
- R1: The window is open only while both enables are set. A control write to region 0 sets the first enable when the value is 0x0A and clears it for any other value. A control write to region 2 sets the second enable when the value is 0x40 and clears it otherwise. Regions 1 and 3 have no effect. While the window is closed, every window read returns 0xFF and every window write is ignored.
- R2: The pin register sits at window page 8 (offset 0x80). In it, bit 7 is chip-select, bit 6 is clock, bit 1 is data-in and bit 0 is data-out. Reads of any other page return 0xFF. After reset the pin register reads 0x01, the write-enable latch is clear and every word holds 0xFFFF.
- R3: In idle, a rising clock with data-in at 1 is the start bit, and rising clocks with data-in at 0 are ignored. After the start bit, 10 command bits are taken on rising clocks, MSB first. Command bits 9:8 are the opcode (01 write, 10 read, 11 erase, 00 extended), bits 7:6 are the extended sub-code, and bits 6:0 are the word address.
- R4: On the rising clock that carries the last command bit of a read, data-out goes low as a dummy bit. Each of the next 16 rising clocks then presents one bit of the addressed word, MSB first. After the 16th bit the engine returns to idle.
- R5: A write takes 16 more data bits, MSB first, and stores them at the addressed word when write-enable is set.
- R6: An erase sets the addressed word to 0xFFFF when write-enable is set, and leaves other words alone.
- R7: The extended sub-codes are: 11 sets write-enable, 00 clears it, 10 erases all words to 0xFFFF, and 01 takes 16 data bits and writes them to all words.
- R8: While write-enable is clear, write, erase, write-all and erase-all leave the array unchanged.
- R9: A rising edge of chip-select returns the engine to idle and abandons any command in progress.
- R10: Data-out reads as 1 except while the engine drives it. On a falling clock with chip-select high, the data-out value is held.
- R11: A write to page 0 whose value has all of bits 0x55 set arms the trigger; any other page-0 value disarms it. A following page-1 write with all of bits 0xAA set produces a sample_pulse of exactly one cycle, in the cycle after that write. Every page-1 write disarms the trigger. Both writes take effect only while the window is open.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control-region write strobe |
| ctl_sel | input | 2 | Control region selected by the write |
| ctl_wdata | input | 8 | Control write value |
| win_we | input | 1 | Window write strobe |
| win_page | input | 4 | Window offset divided by 16, for reads and writes |
| win_wdata | input | 8 | Window write value |
| win_rdata | output | 8 | Window read value for win_page |
| sample_pulse | output | 1 | One-cycle sensor sample strobe |

## Verification
The bench writes a distinct pattern to every one of the 128 words and reads each one back. A design that mis-assembled the address or data bits, or that shifted them out in the wrong order, would fail on many words at once. Each read also checks the leading dummy zero; an engine that skipped it would return every word shifted by one bit. The bench runs every destructive command with write-enable clear and confirms the words are unchanged, which catches a latch that was ignored or came out of reset set. It also drops chip-select in the middle of a write and checks that the target word survives. It checks that data-out holds across a falling clock, that leading zero clocks do not start a command, and that the trigger does not fire on an unarmed, partly matching or gated sequence.

// File: rtl/ser_eeprom_pkg.sv
package ser_eeprom_pkg;

    localparam int PIN_CS  = 7;
    localparam int PIN_CLK = 6;
    localparam int PIN_DI  = 1;
    localparam int PIN_DO  = 0;

    localparam logic [7:0] GATE_A_KEY = 8'h0A;
    localparam logic [7:0] GATE_B_KEY = 8'h40;
    localparam logic [7:0] ARM_MASK   = 8'h55;
    localparam logic [7:0] FIRE_MASK  = 8'hAA;

    localparam logic [3:0] PAGE_ARM  = 4'h0;
    localparam logic [3:0] PAGE_FIRE = 4'h1;
    localparam logic [3:0] PAGE_PINS = 4'h8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_WRITE,
        ST_WRALL,
        ST_DOUT
    } eng_state_e;

endpackage

// File: rtl/ser_access_gate.sv
module ser_access_gate
    import ser_eeprom_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_we,
    input  logic [1:0] ctl_sel,
    input  logic [7:0] ctl_wdata,
    output logic       open
);
    typedef struct packed {
        logic en_a;
        logic en_b;
    } gate_t;

    gate_t gate_d, gate_q;

    always_comb begin
        gate_d = gate_q;
        if (ctl_we) begin
            case (ctl_sel)
                2'd0:    gate_d.en_a = (ctl_wdata == GATE_A_KEY);
                2'd2:    gate_d.en_b = (ctl_wdata == GATE_B_KEY);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) gate_q <= '0;
        else        gate_q <= gate_d;
    end

    assign open = gate_q.en_a & gate_q.en_b;

    // R1
    gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_we |=> $stable(open));
endmodule

// File: rtl/ser_sample_trig.sv
module ser_sample_trig
    import ser_eeprom_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [3:0] page,
    input  logic [7:0] wdata,
    output logic       strobe
);
    typedef struct packed {
        logic armed;
        logic fire;
    } trig_t;

    trig_t trig_d, trig_q;

    always_comb begin
        trig_d      = trig_q;
        trig_d.fire = 1'b0;
        if (we && page == PAGE_ARM) begin
            trig_d.armed = ((wdata & ARM_MASK) == ARM_MASK);
        end
        if (we && page == PAGE_FIRE) begin
            trig_d.fire  = trig_q.armed && ((wdata & FIRE_MASK) == FIRE_MASK);
            trig_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trig_q <= '0;
        else        trig_q <= trig_d;
    end

    assign strobe = trig_q.fire;

    // R11
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);
endmodule

// File: rtl/ser_word_store.sv
module ser_word_store #(
    parameter int WORDS = 128,
    parameter int WIDTH = 16,
    localparam int ADDR_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_one,
    input  logic              we_all,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WIDTH-1:0]  wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WIDTH-1:0]  rdata
);
    logic [WIDTH-1:0] mem_q [WORDS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem_q[i] <= '1;
        end else if (we_all) begin
            for (int i = 0; i < WORDS; i++) mem_q[i] <= wdata;
        end else if (we_one) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

    // R7
    single_port_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({we_one, we_all}));
endmodule

// File: rtl/ser_wire_engine.sv
module ser_wire_engine
    import ser_eeprom_pkg::*;
#(
    parameter int WORDS = 128,
    parameter int WIDTH = 16,
    localparam int ADDR_W   = $clog2(WORDS),
    localparam int CMD_BITS = ADDR_W + 3,
    localparam int CNT_W    = $clog2(WIDTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_value,
    output logic              mem_we_one,
    output logic              mem_we_all,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [WIDTH-1:0]  mem_wdata,
    output logic [ADDR_W-1:0] mem_raddr,
    input  logic [WIDTH-1:0]  mem_rdata
);
    typedef struct packed {
        eng_state_e        state;
        logic [WIDTH-1:0]  sr;
        logic [CNT_W-1:0]  bits;
        logic [ADDR_W-1:0] addr;
        logic              wen;
        logic [7:0]        pins;
    } eng_t;

    eng_t eng_d, eng_q;
    logic [7:0] pv;
    logic [1:0] opc, ext;
    logic       clk_rise, clk_fall, cs_rise;

    assign clk_rise  = !eng_q.pins[PIN_CLK] && reg_wdata[PIN_CLK];
    assign clk_fall  = eng_q.pins[PIN_CLK] && !reg_wdata[PIN_CLK];
    assign cs_rise   = !eng_q.pins[PIN_CS] && reg_wdata[PIN_CS];
    assign mem_raddr = {eng_q.sr[ADDR_W-2:0], reg_wdata[PIN_DI]};

    always_comb begin
        eng_d      = eng_q;
        mem_we_one = 1'b0;
        mem_we_all = 1'b0;
        mem_waddr  = eng_q.addr;
        mem_wdata  = eng_q.sr;
        pv         = reg_wdata;
        pv[PIN_DO] = 1'b1;
        opc        = '0;
        ext        = '0;
        if (reg_we) begin
            if (cs_rise) eng_d.state = ST_IDLE;
            if (clk_rise) begin
                if (eng_d.state == ST_CMD || eng_d.state == ST_WRITE ||
                    eng_d.state == ST_WRALL) begin
                    eng_d.sr   = {eng_d.sr[WIDTH-2:0], reg_wdata[PIN_DI]};
                    eng_d.bits = eng_d.bits + 1'b1;
                end
                opc = eng_d.sr[CMD_BITS-1:CMD_BITS-2];
                ext = eng_d.sr[CMD_BITS-3:CMD_BITS-4];
                case (eng_d.state)
                    ST_IDLE: begin
                        if (reg_wdata[PIN_DI]) begin
                            eng_d.state = ST_CMD;
                            eng_d.bits  = '0;
                            eng_d.sr    = '0;
                        end
                    end
                    ST_CMD: begin
                        if (eng_d.bits == CNT_W'(CMD_BITS)) begin
                            eng_d.bits  = '0;
                            eng_d.addr  = eng_d.sr[ADDR_W-1:0];
                            eng_d.state = ST_IDLE;
                            mem_waddr   = eng_d.sr[ADDR_W-1:0];
                            mem_wdata   = '1;
                            case (opc)
                                2'b01: eng_d.state = ST_WRITE;
                                2'b10: begin
                                    eng_d.sr    = mem_rdata;
                                    eng_d.bits  = CNT_W'(WIDTH);
                                    eng_d.state = ST_DOUT;
                                    pv[PIN_DO]  = 1'b0;
                                end
                                2'b11: mem_we_one = eng_q.wen;
                                default: begin
                                    case (ext)
                                        2'b11:   eng_d.wen = 1'b1;
                                        2'b00:   eng_d.wen = 1'b0;
                                        2'b10:   mem_we_all = eng_q.wen;
                                        default: eng_d.state = ST_WRALL;
                                    endcase
                                end
                            endcase
                        end
                    end
                    ST_WRITE, ST_WRALL: begin
                        if (eng_d.bits == CNT_W'(WIDTH)) begin
                            mem_wdata = eng_d.sr;
                            if (eng_d.state == ST_WRITE) mem_we_one = eng_q.wen;
                            else                         mem_we_all = eng_q.wen;
                            eng_d.state = ST_IDLE;
                        end
                    end
                    ST_DOUT: begin
                        pv[PIN_DO] = eng_d.sr[WIDTH-1];
                        eng_d.sr   = {eng_d.sr[WIDTH-2:0], 1'b0};
                        eng_d.bits = eng_d.bits - 1'b1;
                        if (eng_d.bits == '0) eng_d.state = ST_IDLE;
                    end
                    default: eng_d.state = ST_IDLE;
                endcase
            end else if (reg_wdata[PIN_CS] && clk_fall) begin
                pv[PIN_DO] = eng_q.pins[PIN_DO];
            end
            eng_d.pins = pv;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_q       <= '0;
            eng_q.state <= ST_IDLE;
            eng_q.pins  <= 8'h01;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign reg_value = eng_q.pins;

    // R9
    cs_rise_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && cs_rise && !clk_rise) |=> (eng_q.state == ST_IDLE));

    // R8
    wen_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_q.wen |-> !(mem_we_one || mem_we_all));

    // R10
    do_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_wdata[PIN_CS] && clk_fall) |=> $stable(reg_value[PIN_DO]));

    // R4
    dout_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.state == ST_DOUT) |-> (eng_q.bits != '0));
endmodule

// File: rtl/ser_eeprom_top.sv
module ser_eeprom_top
    import ser_eeprom_pkg::*;
#(
    parameter int WORDS = 128,
    parameter int WIDTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_we,
    input  logic [1:0] ctl_sel,
    input  logic [7:0] ctl_wdata,
    input  logic       win_we,
    input  logic [3:0] win_page,
    input  logic [7:0] win_wdata,
    output logic [7:0] win_rdata,
    output logic       sample_pulse
);
    localparam int ADDR_W = $clog2(WORDS);

    logic              gate_open, pins_we, live_we;
    logic [7:0]        pins_value;
    logic              m_we_one, m_we_all;
    logic [ADDR_W-1:0] m_waddr, m_raddr;
    logic [WIDTH-1:0]  m_wdata, m_rdata;

    ser_access_gate u_gate (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_sel(ctl_sel),
        .ctl_wdata(ctl_wdata), .open(gate_open)
    );

    assign live_we = win_we & gate_open;
    assign pins_we = live_we & (win_page == PAGE_PINS);

    ser_sample_trig u_trig (
        .clk(clk), .rst_n(rst_n), .we(live_we), .page(win_page),
        .wdata(win_wdata), .strobe(sample_pulse)
    );

    ser_wire_engine #(.WORDS(WORDS), .WIDTH(WIDTH)) u_eng (
        .clk(clk), .rst_n(rst_n), .reg_we(pins_we), .reg_wdata(win_wdata),
        .reg_value(pins_value), .mem_we_one(m_we_one), .mem_we_all(m_we_all),
        .mem_waddr(m_waddr), .mem_wdata(m_wdata), .mem_raddr(m_raddr),
        .mem_rdata(m_rdata)
    );

    ser_word_store #(.WORDS(WORDS), .WIDTH(WIDTH)) u_store (
        .clk(clk), .rst_n(rst_n), .we_one(m_we_one), .we_all(m_we_all),
        .waddr(m_waddr), .wdata(m_wdata), .raddr(m_raddr), .rdata(m_rdata)
    );

    assign win_rdata = (gate_open && win_page == PAGE_PINS) ? pins_value : 8'hFF;

    // R1
    closed_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_open |=> $stable(pins_value));
endmodule

// File: tb/tb_ser_eeprom_top.sv
module tb_ser_eeprom_top;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       ctl_we = 0;
    logic [1:0] ctl_sel = 0;
    logic [7:0] ctl_wdata = 0;
    logic       win_we = 0;
    logic [3:0] win_page = 0;
    logic [7:0] win_wdata = 0;
    logic [7:0] win_rdata;
    logic       sample_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    ser_eeprom_top dut (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_sel(ctl_sel),
        .ctl_wdata(ctl_wdata), .win_we(win_we), .win_page(win_page),
        .win_wdata(win_wdata), .win_rdata(win_rdata), .sample_pulse(sample_pulse)
    );

    always #5 clk = ~clk;

    function automatic logic [15:0] pat(input int a);
        return 16'(a * 16'h0203) ^ 16'hC35A;
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic ctl_wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk); ctl_we = 1; ctl_sel = s; ctl_wdata = d;
        @(negedge clk); ctl_we = 0;
    endtask

    task automatic bus_wr(input logic [3:0] p, input logic [7:0] d);
        @(negedge clk); win_we = 1; win_page = p; win_wdata = d;
        @(negedge clk); win_we = 0;
    endtask

    task automatic rd(input logic [3:0] p, output logic [7:0] v);
        win_page = p; #1; v = win_rdata;
    endtask

    task automatic pin(input logic cs, input logic ck, input logic di);
        bus_wr(4'h8, {cs, ck, 4'b0, di, 1'b0});
    endtask

    task automatic get_do(output logic b);
        logic [7:0] v;
        rd(4'h8, v); b = v[0];
    endtask

    task automatic clk_bit(input logic di);
        pin(1, 0, di); pin(1, 1, di);
    endtask

    task automatic send_cmd(input logic [9:0] c, input int lead);
        pin(0, 0, 0); pin(1, 0, 0);
        for (int i = 0; i < lead; i++) clk_bit(0);
        clk_bit(1);
        for (int i = 9; i >= 0; i--) clk_bit(c[i]);
    endtask

    task automatic send_data(input logic [15:0] d);
        for (int i = 15; i >= 0; i--) clk_bit(d[i]);
        pin(0, 0, 0);
    endtask

    task automatic ext_cmd(input logic [1:0] sub);
        send_cmd({2'b00, sub, 6'b0}, 0); pin(0, 0, 0);
    endtask

    task automatic wr_word(input int a, input logic [15:0] d);
        send_cmd({2'b01, 1'b0, 7'(a)}, 0); send_data(d);
    endtask

    task automatic erase_word(input int a);
        send_cmd({2'b11, 1'b0, 7'(a)}, 0); pin(0, 0, 0);
    endtask

    task automatic rd_word(input int a, input int lead, output logic [15:0] w);
        logic b;
        send_cmd({2'b10, 1'b0, 7'(a)}, lead);
        get_do(b);
        check("R4 dummy bit", {15'b0, b}, 16'h0);
        for (int i = 15; i >= 0; i--) begin
            clk_bit(0); get_do(b); w[i] = b;
        end
        pin(0, 0, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0]  v;
        logic [15:0] w;
        logic        b;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 closed window
        rd(4'h8, v); check("R1 closed read", {8'h0, v}, 16'h00FF);
        ctl_wr(2'd0, 8'h0A);
        rd(4'h8, v); check("R1 one enable read", {8'h0, v}, 16'h00FF);
        pin(1, 1, 1);
        ctl_wr(2'd2, 8'h40);
        // R2 reset value, R1 write ignored
        rd(4'h8, v); check("R1 R2 pins after gated write", {8'h0, v}, 16'h0001);
        rd(4'h4, v); check("R2 other page", {8'h0, v}, 16'h00FF);
        ctl_wr(2'd0, 8'h0B);
        rd(4'h8, v); check("R1 enable cleared", {8'h0, v}, 16'h00FF);
        ctl_wr(2'd1, 8'h0A); ctl_wr(2'd3, 8'h40);
        rd(4'h8, v); check("R1 other regions", {8'h0, v}, 16'h00FF);
        ctl_wr(2'd0, 8'h0A);

        rd_word(0, 0, w); check("R2 reset word", w, 16'hFFFF);

        // R8 write while latch clear after reset
        wr_word(5, 16'h1234);
        rd_word(5, 0, w); check("R8 write disabled", w, 16'hFFFF);

        // R7 enable, then R5 sweep
        ext_cmd(2'b11);
        for (int a = 0; a < 128; a++) wr_word(a, pat(a));
        for (int a = 0; a < 128; a++) begin
            rd_word(a, (a % 3), w); check("R5 R3 sweep word", w, pat(a));
        end

        // R6 erase
        erase_word(3);
        rd_word(3, 0, w); check("R6 erased word", w, 16'hFFFF);
        rd_word(2, 0, w); check("R6 neighbour low", w, pat(2));
        rd_word(4, 0, w); check("R6 neighbour high", w, pat(4));

        // R10 hold on falling clock, release in idle
        send_cmd({2'b10, 1'b0, 7'd2}, 0);
        clk_bit(0); get_do(b);
        check("R10 first bit", {15'b0, b}, {15'b0, pat(2)[15]});
        pin(1, 0, 0); get_do(b);
        check("R10 falling hold", {15'b0, b}, {15'b0, pat(2)[15]});
        pin(0, 0, 0);
        rd(4'h8, v); check("R10 released", {8'h0, v}, 16'h0001);

        // R9 abort mid-read and mid-write
        rd_word(6, 0, w); check("R9 read after abort", w, pat(6));
        send_cmd({2'b01, 1'b0, 7'd7}, 0);
        for (int i = 0; i < 5; i++) clk_bit(1);
        pin(0, 0, 0);
        rd_word(7, 0, w); check("R9 write abandoned", w, pat(7));

        // R8 disable, then all destructive commands
        ext_cmd(2'b00);
        wr_word(4, 16'h0F0F);
        erase_word(4);
        send_cmd({2'b00, 2'b01, 6'b0}, 0); send_data(16'h1111);
        ext_cmd(2'b10);
        rd_word(4, 0, w); check("R8 disabled ops", w, pat(4));
        rd_word(100, 0, w); check("R8 disabled bulk", w, pat(100));

        // R7 write-all, erase-all
        ext_cmd(2'b11);
        send_cmd({2'b00, 2'b01, 6'b0}, 0); send_data(16'hA5C3);
        rd_word(0, 0, w);   check("R7 write-all 0", w, 16'hA5C3);
        rd_word(64, 0, w);  check("R7 write-all 64", w, 16'hA5C3);
        rd_word(127, 0, w); check("R7 write-all 127", w, 16'hA5C3);
        ext_cmd(2'b10);
        rd_word(0, 0, w);   check("R7 erase-all 0", w, 16'hFFFF);
        rd_word(127, 0, w); check("R7 erase-all 127", w, 16'hFFFF);

        // R11 sample trigger
        bus_wr(4'h0, 8'h55);
        @(negedge clk); win_we = 1; win_page = 4'h1; win_wdata = 8'hAA;
        @(negedge clk); win_we = 0;
        check("R11 strobe", {15'b0, sample_pulse}, 16'h1);
        @(negedge clk);
        check("R11 strobe width", {15'b0, sample_pulse}, 16'h0);
        bus_wr(4'h1, 8'hFF);
        check("R11 disarmed after fire", {15'b0, sample_pulse}, 16'h0);
        bus_wr(4'h0, 8'h54); bus_wr(4'h1, 8'hFF);
        check("R11 partial arm", {15'b0, sample_pulse}, 16'h0);
        bus_wr(4'h0, 8'hFF); bus_wr(4'h1, 8'h2A);
        check("R11 partial fire", {15'b0, sample_pulse}, 16'h0);
        bus_wr(4'h0, 8'h55); bus_wr(4'h8, 8'h01); bus_wr(4'h1, 8'hAA);
        check("R11 pin write between", {15'b0, sample_pulse}, 16'h1);
        ctl_wr(2'd2, 8'h00);
        bus_wr(4'h0, 8'h55); bus_wr(4'h1, 8'hAA);
        check("R11 R1 gated trigger", {15'b0, sample_pulse}, 16'h0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule